// File: doc/BRIEF.md
# Divide Special-Operand Screen

This block sits in front of an extended-precision divider. Each transaction carries a dividend and a divisor. The divisor is either a floating-point operand or a signed integer, which the block first turns into the extended format. The block sorts both operands into classes and decides whether the division can be resolved without the quotient datapath. It can be resolved that way when the answer is a NaN, an infinity or a zero, or when an exception takes over.

When the operation is resolved here, the block presents three things. The first is a bypass indication. The second is the value to write. The third is a store enable that honours the invalid and zero-divide mask bits. It also raises invalid-operation, zero-divide, denormal-operand and stack-fault flags. The operands are always passed through with the result, in normalized extended form, for use by the divider.

The floating-point layout is `{sign, exponent[EXP_W], significand[MAN_W]}`. The significand carries an explicit leading integer bit at position MAN_W-1, and the exponent bias is 2^(EXP_W-1)-1.

The input and output are valid/ready streams with a single register stage between them. `in_ready` is high when the output register is empty or is being drained in the same cycle. A result stays registered and unchanged for as long as `res_valid` is high and `res_ready` is low. The control inputs travel with the operand beat: the integer select, the narrow-integer select, the underflow input and the two mask bits.

Top module: `divspec_unit`

## Requirements
- R1: `in_ready` equals `!res_valid || res_ready`. A beat accepted at a clock edge appears on `res_*` after that same edge. While `res_valid && !res_ready`, every `res_*` output holds its value.
- R2: Operand classes are decided as follows.
  - Exponent all ones:
    - Integer bit 0 is an unsupported format.
    - Integer bit 1 with all fraction bits 0 is infinity.
    - Integer bit 1 with fraction bit MAN_W-2 set is a quiet NaN.
    - Integer bit 1 with any other nonzero fraction is a signaling NaN.
  - Exponent zero:
    - A zero significand is zero.
    - Any other significand is denormal.
  - Any other exponent:
    - Integer bit 1 is normal.
    - Integer bit 0 is an unsupported format.
- R3: When `in_underflow` is high, the result sets invalid and stack fault and bypasses, whatever the operands are. It stores only when `in_im` is 1.
- R4: A signaling NaN or unsupported-format operand raises invalid-operation.
- R5: Infinity divided by infinity, and zero divided by zero, raise invalid-operation whatever the signs are.
- R6: For every invalid case in R3 to R5, the block stores only when `in_im` is 1. The value stored is the indefinite NaN, which has sign 1, an exponent of all ones, and a significand whose top two bits are 1 and whose other bits are 0.
- R7: With no invalid case, a quiet NaN operand is passed out unchanged with no flag. If both operands are quiet NaNs, the one with the larger significand is chosen, and the dividend wins a tie.
- R8: A finite nonzero dividend divided by zero raises zero-divide. When `in_zm` is 1, the block stores an infinity with significand 100…0. When `in_zm` is 0, it stores nothing.
- R9: Infinity divided by a finite value (zero included) gives infinity, and a finite value divided by infinity gives zero. Zero divided by a finite nonzero value also gives zero. None of these raises a flag.
- R10: Every result sign in R8 and R9 is the XOR of the operand signs, and this holds for zero operands too.
- R11: A denormal operand raises the denormal flag, except when R3, R4, R5 or R7 applies.
- R12: With `in_int_sel` high, the divisor is taken from `in_int_div`. With `in_int_narrow` high, only the low NARROW_W bits are used, sign-extended. The value is converted to a normalized extended number with the leading one at bit MAN_W-1, and 0 converts to +0 (all bits zero).
- R13: Normal divided by normal gives no bypass, no store and no flags. `res_dividend` and `res_divisor` always carry the operands used, which for an integer divisor means the converted value, and `res_store` is never high without `res_bypass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Operand beat accepted when high together with in_valid |
| in_dividend | input | 1+EXP_W+MAN_W | Dividend, extended format |
| in_divisor | input | 1+EXP_W+MAN_W | Floating-point divisor |
| in_int_div | input | INT_W | Integer divisor, two's complement |
| in_int_sel | input | 1 | Use the integer divisor |
| in_int_narrow | input | 1 | Integer divisor is NARROW_W bits wide |
| in_underflow | input | 1 | The operand fetch hit an empty stack slot |
| in_im | input | 1 | Invalid-operation masked |
| in_zm | input | 1 | Zero-divide masked |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Consumer takes the result |
| res_bypass | output | 1 | The result is decided here, without the quotient datapath |
| res_store | output | 1 | Write res_value to the destination |
| res_value | output | 1+EXP_W+MAN_W | Special result value |
| res_ie | output | 1 | Invalid-operation flag |
| res_ze | output | 1 | Zero-divide flag |
| res_de | output | 1 | Denormal-operand flag |
| res_sf | output | 1 | Stack-fault flag |
| res_dividend | output | 1+EXP_W+MAN_W | Dividend passed to the divider |
| res_divisor | output | 1+EXP_W+MAN_W | Divisor passed to the divider, after integer conversion |

## Verification
The bench builds the block with a 4-bit exponent, an 8-bit significand, an 8-bit wide integer and a 4-bit narrow integer. With these widths, all 256 wide integers and all 16 narrow integers can be converted and checked one by one. The bench also takes a set of operands that covers every class with both signs, including pseudo-denormals, pseudo-infinities and unnormals. It divides every pair of these under all four mask settings, and again with underflow raised. This covers every branch of the decision order together with the sign rule. A stalled-consumer sequence exercises the hold and back-pressure rule.

// File: rtl/divspec_pkg.sv
package divspec_pkg;

  typedef enum logic [2:0] {
    OPC_ZERO   = 3'd0,
    OPC_NORM   = 3'd1,
    OPC_DENORM = 3'd2,
    OPC_INF    = 3'd3,
    OPC_QNAN   = 3'd4,
    OPC_SNAN   = 3'd5,
    OPC_UNSUP  = 3'd6
  } opclass_e;

endpackage

// File: rtl/divspec_int2ext.sv
module divspec_int2ext #(
  parameter int EXP_W    = 15,
  parameter int MAN_W    = 64,
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic [INT_W-1:0]         int_in,
  input  logic                     narrow,
  output logic [EXP_W+MAN_W:0]     fp_out
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [INT_W-1:0] sext;
  logic [INT_W-1:0] mag;
  logic             neg;
  int               msb;
  logic [EXP_W-1:0] exp_v;
  logic [MAN_W-1:0] man_v;

  always_comb begin
    sext = narrow ? {{(INT_W-NARROW_W){int_in[NARROW_W-1]}}, int_in[NARROW_W-1:0]}
                  : int_in;
    neg  = sext[INT_W-1];
    mag  = neg ? (~sext + 1'b1) : sext;
    msb  = 0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) msb = i;
    end
    exp_v = EXP_W'(BIAS + msb);
    man_v = MAN_W'(mag) << (MAN_W - 1 - msb);
    if (mag == '0) fp_out = '0;
    else           fp_out = {neg, exp_v, man_v};
  end

  // R12
  always_comb begin
    if (mag != '0) begin
      lead_one_chk: assert (fp_out[MAN_W-1]);
    end
  end

endmodule

// File: rtl/divspec_opclass.sv
module divspec_opclass
  import divspec_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] opnd,
  output opclass_e             cls
);
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic             jbit;
  logic             quiet;
  logic             frac_nz;

  always_comb begin
    e       = opnd[MAN_W +: EXP_W];
    m       = opnd[MAN_W-1:0];
    jbit    = m[MAN_W-1];
    quiet   = m[MAN_W-2];
    frac_nz = |m[MAN_W-2:0];
    if (&e) begin
      if (!jbit)        cls = OPC_UNSUP;
      else if (!frac_nz) cls = OPC_INF;
      else if (quiet)   cls = OPC_QNAN;
      else              cls = OPC_SNAN;
    end else if (e == '0) begin
      cls = (m == '0) ? OPC_ZERO : OPC_DENORM;
    end else begin
      cls = jbit ? OPC_NORM : OPC_UNSUP;
    end
  end

endmodule

// File: rtl/divspec_decide.sv
module divspec_decide
  import divspec_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] dvd,
  input  logic [EXP_W+MAN_W:0] dvs,
  input  opclass_e             cls_a,
  input  opclass_e             cls_b,
  input  logic                 underflow,
  input  logic                 im,
  input  logic                 zm,
  output logic                 bypass,
  output logic                 store,
  output logic [EXP_W+MAN_W:0] value,
  output logic                 ie,
  output logic                 ze,
  output logic                 de,
  output logic                 sf
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  localparam logic [FP_W-1:0] INDEF =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

  logic sgn;
  logic bad_a, bad_b;
  logic fin_a;

  always_comb begin
    sgn    = dvd[FP_W-1] ^ dvs[FP_W-1];
    bad_a  = (cls_a == OPC_SNAN) || (cls_a == OPC_UNSUP);
    bad_b  = (cls_b == OPC_SNAN) || (cls_b == OPC_UNSUP);
    fin_a  = (cls_a == OPC_NORM) || (cls_a == OPC_DENORM);
    bypass = 1'b0;
    store  = 1'b0;
    value  = '0;
    ie     = 1'b0;
    ze     = 1'b0;
    de     = 1'b0;
    sf     = 1'b0;
    if (underflow) begin
      bypass = 1'b1; ie = 1'b1; sf = 1'b1; store = im; value = INDEF;
    end else if (bad_a || bad_b) begin
      bypass = 1'b1; ie = 1'b1; store = im; value = INDEF;
    end else if (cls_a == OPC_QNAN || cls_b == OPC_QNAN) begin
      bypass = 1'b1; store = 1'b1;
      if (cls_a == OPC_QNAN && cls_b == OPC_QNAN)
        value = (dvs[MAN_W-1:0] > dvd[MAN_W-1:0]) ? dvs : dvd;
      else
        value = (cls_a == OPC_QNAN) ? dvd : dvs;
    end else if ((cls_a == OPC_INF && cls_b == OPC_INF) ||
                 (cls_a == OPC_ZERO && cls_b == OPC_ZERO)) begin
      bypass = 1'b1; ie = 1'b1; store = im; value = INDEF;
    end else begin
      de = (cls_a == OPC_DENORM) || (cls_b == OPC_DENORM);
      if (cls_b == OPC_ZERO) begin
        bypass = 1'b1;
        value  = {sgn, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
        if (fin_a) begin
          ze    = 1'b1;
          store = zm;
        end else begin
          store = 1'b1;
        end
      end else if (cls_a == OPC_INF) begin
        bypass = 1'b1; store = 1'b1;
        value  = {sgn, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
      end else if (cls_b == OPC_INF || cls_a == OPC_ZERO) begin
        bypass = 1'b1; store = 1'b1;
        value  = {sgn, {(FP_W-1){1'b0}}};
      end
    end
  end

endmodule

// File: rtl/divspec_unit.sv
module divspec_unit
  import divspec_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MAN_W    = 64,
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [EXP_W+MAN_W:0]     in_dividend,
  input  logic [EXP_W+MAN_W:0]     in_divisor,
  input  logic [INT_W-1:0]         in_int_div,
  input  logic                     in_int_sel,
  input  logic                     in_int_narrow,
  input  logic                     in_underflow,
  input  logic                     in_im,
  input  logic                     in_zm,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic                     res_bypass,
  output logic                     res_store,
  output logic [EXP_W+MAN_W:0]     res_value,
  output logic                     res_ie,
  output logic                     res_ze,
  output logic                     res_de,
  output logic                     res_sf,
  output logic [EXP_W+MAN_W:0]     res_dividend,
  output logic [EXP_W+MAN_W:0]     res_divisor
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  logic [FP_W-1:0] conv_div;
  logic [FP_W-1:0] opnd [2];
  opclass_e        cls  [2];

  divspec_int2ext #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .NARROW_W(NARROW_W)
  ) u_cvt (
    .int_in (in_int_div),
    .narrow (in_int_narrow),
    .fp_out (conv_div)
  );

  assign opnd[0] = in_dividend;
  assign opnd[1] = in_int_sel ? conv_div : in_divisor;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    divspec_opclass #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .opnd (opnd[g]),
      .cls  (cls[g])
    );
  end

  logic            d_bypass, d_store, d_ie, d_ze, d_de, d_sf;
  logic [FP_W-1:0] d_value;

  divspec_decide #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
    .dvd       (opnd[0]),
    .dvs       (opnd[1]),
    .cls_a     (cls[0]),
    .cls_b     (cls[1]),
    .underflow (in_underflow),
    .im        (in_im),
    .zm        (in_zm),
    .bypass    (d_bypass),
    .store     (d_store),
    .value     (d_value),
    .ie        (d_ie),
    .ze        (d_ze),
    .de        (d_de),
    .sf        (d_sf)
  );

  logic im_q, zm_q;
  logic take;

  assign in_ready = !res_valid || res_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_bypass   <= 1'b0;
      res_store    <= 1'b0;
      res_value    <= '0;
      res_ie       <= 1'b0;
      res_ze       <= 1'b0;
      res_de       <= 1'b0;
      res_sf       <= 1'b0;
      res_dividend <= '0;
      res_divisor  <= '0;
      im_q         <= 1'b0;
      zm_q         <= 1'b0;
    end else begin
      if (take) begin
        res_valid    <= 1'b1;
        res_bypass   <= d_bypass;
        res_store    <= d_store;
        res_value    <= d_value;
        res_ie       <= d_ie;
        res_ze       <= d_ze;
        res_de       <= d_de;
        res_sf       <= d_sf;
        res_dividend <= opnd[0];
        res_divisor  <= opnd[1];
        im_q         <= in_im;
        zm_q         <= in_zm;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_value) &&
      $stable(res_bypass) && $stable(res_store) && $stable(res_divisor));

  // R3
  sf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_sf |-> res_ie && res_bypass);

  // R6
  unmasked_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ie && !im_q |-> !res_store);

  // R8
  ze_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ze |-> (res_store == zm_q) && !res_ie &&
      (&res_value[MAN_W +: EXP_W]));

  // R13
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_store |-> res_bypass);

endmodule

// File: tb/tb_divspec_unit.sv
module tb_divspec_unit;
  localparam int EW = 4;
  localparam int MW = 8;
  localparam int IW = 8;
  localparam int NW = 4;
  localparam int FW = 1 + EW + MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0, in_ready;
  logic [FW-1:0] in_dividend = '0, in_divisor = '0;
  logic [IW-1:0] in_int_div = '0;
  logic          in_int_sel = 1'b0, in_int_narrow = 1'b0, in_underflow = 1'b0;
  logic          in_im = 1'b0, in_zm = 1'b0;
  logic          res_valid, res_ready = 1'b1;
  logic          res_bypass, res_store, res_ie, res_ze, res_de, res_sf;
  logic [FW-1:0] res_value, res_dividend, res_divisor;

  divspec_unit #(.EXP_W(EW), .MAN_W(MW), .INT_W(IW), .NARROW_W(NW)) dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_dividend, .in_divisor,
    .in_int_div, .in_int_sel, .in_int_narrow, .in_underflow, .in_im, .in_zm,
    .res_valid, .res_ready, .res_bypass, .res_store, .res_value,
    .res_ie, .res_ze, .res_de, .res_sf, .res_dividend, .res_divisor
  );

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic          byp;
    logic          st;
    logic [FW-1:0] val;
    logic          ie, ze, de, sf;
  } exp_t;

  // class codes: 0 zero 1 normal 2 denormal 3 inf 4 qnan 5 snan 6 unsupported
  function automatic int klass(logic [FW-1:0] v);
    int e = int'(v[MW +: EW]);
    int m = int'(v[MW-1:0]);
    if (e == 15) begin
      if (m < 128)       return 6;
      if (m == 128)      return 3;
      if (m >= 192)      return 4;
      return 5;
    end
    if (e == 0) return (m == 0) ? 0 : 2;
    return (m >= 128) ? 1 : 6;
  endfunction

  function automatic exp_t model(logic [FW-1:0] a, logic [FW-1:0] b,
                                 logic uf, logic im, logic zm);
    exp_t r = '0;
    int ka = klass(a);
    int kb = klass(b);
    logic s = a[FW-1] ^ b[FW-1];
    logic [FW-1:0] indef = {1'b1, 4'hF, 8'hC0};
    logic [FW-1:0] inf   = {s, 4'hF, 8'h80};
    logic [FW-1:0] zer   = {s, 12'h000};
    if (uf) begin
      r.byp = 1; r.ie = 1; r.sf = 1; r.st = im; r.val = indef;
    end else if (ka >= 5 || kb >= 5 || (ka == 3 && kb == 3) || (ka == 0 && kb == 0)) begin
      r.byp = 1; r.ie = 1; r.st = im; r.val = indef;
    end else if (ka == 4 || kb == 4) begin
      r.byp = 1; r.st = 1;
      if (ka == 4 && kb == 4) r.val = (b[MW-1:0] > a[MW-1:0]) ? b : a;
      else r.val = (ka == 4) ? a : b;
    end else begin
      r.de = (ka == 2 || kb == 2);
      if (kb == 0 && (ka == 1 || ka == 2)) begin
        r.byp = 1; r.ze = 1; r.st = zm; r.val = inf;
      end else if (ka == 3) begin
        r.byp = 1; r.st = 1; r.val = inf;
      end else if (kb == 3 || ka == 0) begin
        r.byp = 1; r.st = 1; r.val = zer;
      end
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] conv(int v);
    int mag, p;
    if (v == 0) return '0;
    mag = (v < 0) ? -v : v;
    p = 0;
    while ((mag >> (p + 1)) != 0) p++;
    return {(v < 0) ? 1'b1 : 1'b0, 4'(7 + p), 8'(mag << (7 - p))};
  endfunction

  function automatic logic [FW-1:0] mk(logic s, int e, int m);
    return {s, 4'(e), 8'(m)};
  endfunction

  task automatic check(string req, logic ok, string act, string expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  task automatic send(logic [FW-1:0] a, logic [FW-1:0] b, logic isel,
                      logic narrow, logic [IW-1:0] iv, logic uf, logic im, logic zm);
    @(negedge clk);
    in_dividend = a; in_divisor = b; in_int_sel = isel; in_int_narrow = narrow;
    in_int_div = iv; in_underflow = uf; in_im = im; in_zm = zm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare(string req, exp_t e, logic [FW-1:0] a, logic [FW-1:0] b);
    logic ok;
    ok = res_valid && res_bypass == e.byp && res_store == e.st && res_ie == e.ie &&
         res_ze == e.ze && res_de == e.de && res_sf == e.sf &&
         (!e.st || res_value == e.val) && res_dividend == a && res_divisor == b;
    check(req, ok,
      $sformatf("v%0b b%0b s%0b val%h ie%0b ze%0b de%0b sf%0b dvd%h dvs%h", res_valid,
        res_bypass, res_store, res_value, res_ie, res_ze, res_de, res_sf, res_dividend, res_divisor),
      $sformatf("v1 b%0b s%0b val%h ie%0b ze%0b de%0b sf%0b dvd%h dvs%h", e.byp, e.st, e.val,
        e.ie, e.ze, e.de, e.sf, a, b));
  endtask

  function automatic string tag(int ka, int kb, logic uf);
    if (uf) return "R3";
    if (ka >= 5 || kb >= 5) return "R4/R6";
    if (ka == 4 || kb == 4) return "R7";
    if ((ka == 3 && kb == 3) || (ka == 0 && kb == 0)) return "R5/R6";
    if (kb == 0) return "R8/R10";
    if (ka == 3 || kb == 3 || ka == 0) return "R9/R10";
    if (ka == 2 || kb == 2) return "R11";
    return "R13";
  endfunction

  logic [FW-1:0] vals [22];

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      vals[s*11+0]  = mk(s[0], 0, 8'h00);
      vals[s*11+1]  = mk(s[0], 1, 8'h80);
      vals[s*11+2]  = mk(s[0], 7, 8'hC5);
      vals[s*11+3]  = mk(s[0], 0, 8'h05);
      vals[s*11+4]  = mk(s[0], 0, 8'h81);
      vals[s*11+5]  = mk(s[0], 15, 8'h80);
      vals[s*11+6]  = mk(s[0], 15, 8'hC3);
      vals[s*11+7]  = mk(s[0], 15, 8'hE0);
      vals[s*11+8]  = mk(s[0], 15, 8'h81);
      vals[s*11+9]  = mk(s[0], 15, 8'h00);
      vals[s*11+10] = mk(s[0], 3, 8'h40);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", !res_valid && in_ready,
          $sformatf("valid%0b ready%0b", res_valid, in_ready), "valid0 ready1");
    rst_n = 1'b1;

    // R2..R11, R13 class cross product under all mask settings
    for (int i = 0; i < 22; i++)
      for (int j = 0; j < 22; j++)
        for (int mk2 = 0; mk2 < 4; mk2++) begin
          exp_t e;
          e = model(vals[i], vals[j], 1'b0, mk2[0], mk2[1]);
          send(vals[i], vals[j], 1'b0, 1'b0, '0, 1'b0, mk2[0], mk2[1]);
          compare(tag(klass(vals[i]), klass(vals[j]), 1'b0), e, vals[i], vals[j]);
        end

    // R3 underflow overrides any operands
    for (int i = 0; i < 22; i += 3)
      for (int im = 0; im < 2; im++) begin
        exp_t e;
        e = model(vals[i], vals[21 - i], 1'b1, im[0], 1'b1);
        send(vals[i], vals[21 - i], 1'b0, 1'b0, '0, 1'b1, im[0], 1'b1);
        compare("R3", e, vals[i], vals[21 - i]);
      end

    // R12 every wide and narrow integer divisor
    for (int v = 0; v < 256; v++) begin
      logic [FW-1:0] d, one;
      int sv;
      exp_t e;
      one = mk(1'b0, 7, 8'h80);
      sv = (v >= 128) ? v - 256 : v;
      d = conv(sv);
      e = model(one, d, 1'b0, 1'b1, 1'b1);
      send(one, '1, 1'b1, 1'b0, 8'(v), 1'b0, 1'b1, 1'b1);
      compare("R12 wide", e, one, d);
    end
    for (int v = 0; v < 16; v++) begin
      logic [FW-1:0] d, one;
      int sv;
      exp_t e;
      one = mk(1'b1, 7, 8'h80);
      sv = (v >= 8) ? v - 16 : v;
      d = conv(sv);
      e = model(one, d, 1'b0, 1'b1, 1'b0);
      send(one, '1, 1'b1, 1'b1, {4'hA, 4'(v)}, 1'b0, 1'b1, 1'b0);
      compare("R12 narrow", e, one, d);
    end

    // R1 back-pressure
    begin
      logic [FW-1:0] a1, b1, a2, b2;
      a1 = vals[1]; b1 = vals[0];
      a2 = vals[5]; b2 = vals[2];
      @(negedge clk);
      res_ready = 1'b0;
      in_dividend = a1; in_divisor = b1; in_int_sel = 1'b0; in_underflow = 1'b0;
      in_im = 1'b1; in_zm = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      in_dividend = a2; in_divisor = b2;
      check("R1 stall ready", !in_ready && res_valid,
            $sformatf("ready%0b valid%0b", in_ready, res_valid), "ready0 valid1");
      @(negedge clk);
      compare("R1 hold", model(a1, b1, 1'b0, 1'b1, 1'b1), a1, b1);
      res_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      compare("R1 drain", model(a2, b2, 1'b0, 1'b1, 1'b1), a2, b2);
      @(negedge clk);
      check("R1 empty", !res_valid && in_ready,
            $sformatf("valid%0b ready%0b", res_valid, in_ready), "valid0 ready1");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule